// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table, each entry an 8-bit red, green and blue triple, and fills it from a simple register bus. The bus exposes two word registers. Writing the pointer register selects the entry to be loaded. Successive writes to the colour register then deliver one component each, always red first, then green, then blue. After the blue write the pointer moves to the next entry by itself, so a full palette can be streamed with one pointer write followed by 768 colour writes. The colour byte is carried in the most significant byte of the 32-bit write word. The bus has no wait states, and every read returns zero.

A pixel pipeline reads the table through a separate lookup port. It presents an entry number and receives that entry's 24-bit colour. The parameter `LOOKUP_REG` selects the read style. With 0 the read is combinational. With 1, the default, the output is registered and has one cycle of latency. In both styles a component write becomes visible on the lookup output in the cycle after the bus accepts it, even when the pipeline is reading that same entry in the same cycle.

A small state machine steps through the components. Its states are `STEP_RED`, `STEP_GRN` and `STEP_BLU`, and it moves on these transitions:
- A pointer write from any state goes to `STEP_RED`.
- A colour write goes from `STEP_RED` to `STEP_GRN`.
- A colour write goes from `STEP_GRN` to `STEP_BLU`.
- A colour write goes from `STEP_BLU` to `STEP_RED` and advances the pointer.
- In every other cycle the state holds.

Top module: `clut_loader`

## Requirements
- R1: After reset, entries 0 to 254 read as 0x000000 and entry 255 reads as 0xFFFFFF. The pointer is 0 and the sequencer is at the red step, so the first colour write after reset loads the red component of entry 0.
- R2: An accepted write to byte offset 0 loads the pointer from write-data bits 31:24 and returns the sequencer to the red step, including when the write arrives in the middle of a triple.
- R3: Accepted writes to byte offset 4 store write-data bits 31:24 into the current entry's red, green and blue components in that order. Bits 23:0 of the write data are ignored. On the lookup output, red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R4: After the blue write the pointer increments modulo 256, so entry 255 is followed by entry 0, and the sequencer returns to red.
- R5: A write is accepted only when `bus_valid` and `bus_write` are both 1 and the address is 0 or 4. Writes to any other offset, and read cycles, change neither the table, the pointer nor the sequencer step.
- R6: `bus_rdata` is zero at all times, including during read cycles.
- R7: A component write is visible on `lut_rgb` in the cycle after it is accepted, including when `lut_idx` selects the entry being written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write word; the colour byte is in bits 31:24 |
| bus_rdata | output | DATA_W (32) | Read data, always zero |
| lut_idx | input | IDX_W (8) | Entry number presented by the pixel pipeline |
| lut_rgb | output | 3*COMP_W (24) | Colour of the entry, as {red, green, blue} |

## Verification
A colour write and a lookup of the same entry can fall in the same cycle. With the registered read this is the one case where the output register and the table are loaded at the same edge. The bench provokes it by driving `lut_idx` equal to the entry being written, for each of the red, green and blue steps. It judges the result in the following cycle against a model table that already contains the new byte, and checks that the two untouched components keep their earlier values. The bench also reads a different entry in the cycle of a write and checks that this entry is unchanged.

// File: rtl/clut_pkg.sv
package clut_pkg;
    typedef enum logic [1:0] {
        STEP_RED = 2'd0,
        STEP_GRN = 2'd1,
        STEP_BLU = 2'd2
    } step_t;
endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int COMP_W    = 8,
    parameter int OFS_INDEX = 0,
    parameter int OFS_DATA  = 4
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic [COMP_W-1:0] wr_byte
);
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(OFS_INDEX);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DATA);

    logic wr_strobe;

    always_comb begin
        wr_strobe = bus_valid && bus_write;
        idx_wr    = wr_strobe && (bus_addr == A_IDX);
        dat_wr    = wr_strobe && (bus_addr == A_DAT);
        wr_byte   = bus_wdata[DATA_W-1 -: COMP_W];
    end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [COMP_W-1:0] wr_byte,
    output logic              wr_en,
    output step_t             wr_comp,
    output logic [IDX_W-1:0]  wr_idx
);
    step_t            step_q, step_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= STEP_RED;
            idx_q  <= '0;
        end else begin
            step_q <= step_d;
            idx_q  <= idx_d;
        end
    end

    always_comb begin
        step_d = step_q;
        idx_d  = idx_q;
        if (idx_wr) begin
            step_d = STEP_RED;
            idx_d  = wr_byte[COMP_W-1 -: IDX_W];
        end else if (dat_wr) begin
            unique case (step_q)
                STEP_RED: step_d = STEP_GRN;
                STEP_GRN: step_d = STEP_BLU;
                STEP_BLU: begin
                    step_d = STEP_RED;
                    idx_d  = idx_q + 1'b1;
                end
                default:  step_d = STEP_RED;
            endcase
        end
    end

    always_comb begin
        wr_en   = dat_wr;
        wr_comp = step_q;
        wr_idx  = idx_q;
    end

    assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (step_q == STEP_RED) && (idx_q == $past(wr_byte[COMP_W-1 -: IDX_W])));

    assert_step_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && step_q == STEP_RED) |=> (step_q == STEP_GRN) && $stable(idx_q));

    assert_index_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && step_q == STEP_BLU) |=>
            (step_q == STEP_RED) && (idx_q == $past(idx_q) + 1'b1));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_wr && !idx_wr) |=> $stable(idx_q) && $stable(step_q));
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int COMP_W     = 8,
    parameter int LOOKUP_REG = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  step_t               wr_comp,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [COMP_W-1:0]   wr_byte,
    input  logic [IDX_W-1:0]    lut_idx,
    output logic [3*COMP_W-1:0] lut_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COMP_W-1:0] red_q [DEPTH];
    logic [COMP_W-1:0] grn_q [DEPTH];
    logic [COMP_W-1:0] blu_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                red_q[i] <= (i == DEPTH-1) ? '1 : '0;
                grn_q[i] <= (i == DEPTH-1) ? '1 : '0;
                blu_q[i] <= (i == DEPTH-1) ? '1 : '0;
            end
        end else if (wr_en) begin
            unique case (wr_comp)
                STEP_RED: red_q[wr_idx] <= wr_byte;
                STEP_GRN: grn_q[wr_idx] <= wr_byte;
                STEP_BLU: blu_q[wr_idx] <= wr_byte;
                default:  ;
            endcase
        end
    end

    logic [3*COMP_W-1:0] rd_now;
    always_comb rd_now = {red_q[lut_idx], grn_q[lut_idx], blu_q[lut_idx]};

    generate
        if (LOOKUP_REG != 0) begin : g_reg
            logic [3*COMP_W-1:0] merged, out_q;
            always_comb begin
                merged = rd_now;
                if (wr_en && (wr_idx == lut_idx)) begin
                    unique case (wr_comp)
                        STEP_RED: merged[3*COMP_W-1 -: COMP_W] = wr_byte;
                        STEP_GRN: merged[2*COMP_W-1 -: COMP_W] = wr_byte;
                        STEP_BLU: merged[COMP_W-1:0]           = wr_byte;
                        default:  ;
                    endcase
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= merged;
            end
            assign lut_rgb = out_q;

            assert_bypass_red_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_comp == STEP_RED && wr_idx == lut_idx) |=>
                    lut_rgb[3*COMP_W-1 -: COMP_W] == $past(wr_byte));
        end else begin : g_comb
            assign lut_rgb = rd_now;

            assert_visible_red_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_comp == STEP_RED) |=>
                    (lut_idx != $past(wr_idx)) || (lut_rgb[3*COMP_W-1 -: COMP_W] == $past(wr_byte)));
        end
    endgenerate
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 8,
    parameter int COMP_W     = 8,
    parameter int LOOKUP_REG = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]    lut_idx,
    output logic [3*COMP_W-1:0] lut_rgb
);
    logic              idx_wr, dat_wr, wr_en;
    logic [COMP_W-1:0] wr_byte;
    logic [IDX_W-1:0]  wr_idx;
    step_t             wr_comp;

    assign bus_rdata = '0;

    clut_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMP_W(COMP_W)) u_dec (
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .idx_wr(idx_wr), .dat_wr(dat_wr), .wr_byte(wr_byte)
    );

    clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .wr_byte(wr_byte),
        .wr_en(wr_en), .wr_comp(wr_comp), .wr_idx(wr_idx)
    );

    clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LOOKUP_REG(LOOKUP_REG)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_comp(wr_comp), .wr_idx(wr_idx),
        .wr_byte(wr_byte), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    assert_read_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |-> !wr_en);
endmodule

// File: tb/clut_loader_tb_top.sv
module clut_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    clut_loader dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    typedef struct {
        logic [23:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    logic [23:0] m_tab [256];
    logic [7:0]  m_ptr;
    int          m_step;

    function automatic void model_reset();
        for (int i = 0; i < 256; i++) m_tab[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
        m_ptr  = 8'd0;
        m_step = 0;
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [31:0] d);
        if (a == 4'd0) begin
            m_ptr  = d[31:24];
            m_step = 0;
        end else if (a == 4'd4) begin
            case (m_step)
                0: m_tab[m_ptr][23:16] = d[31:24];
                1: m_tab[m_ptr][15:8]  = d[31:24];
                default: m_tab[m_ptr][7:0] = d[31:24];
            endcase
            if (m_step == 2) begin
                m_step = 0;
                m_ptr  = m_ptr + 8'd1;
            end else begin
                m_step = m_step + 1;
            end
        end
    endfunction

    // Monitor: compares pending expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (lut_rgb !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: lut_rgb actual %06h expected %06h", it.tag, lut_rgb, it.exp);
                end
            end
        end
    end

    task automatic bus_op(input logic wr, input logic [3:0] a, input logic [31:0] d,
                          input logic [7:0] look, input logic probe, input string tag);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        lut_idx   = look;
        if (wr) model_write(a, d);
        if (probe) sb_q.push_back('{m_tab[look], tag});
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_op(1'b1, a, d, lut_idx, 1'b0, "");
    endtask

    task automatic probe(input logic [7:0] idx, input string tag);
        @(negedge clk);
        lut_idx = idx;
        sb_q.push_back('{m_tab[idx], tag});
        @(negedge clk);
    endtask

    task automatic check_rdata(input string tag);
        n_cmp++;
        if (bus_rdata !== 32'h0) begin
            n_bad++;
            $display("FAIL %s: bus_rdata actual %08h expected 00000000", tag, bus_rdata);
        end
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        probe(8'd0,   "R1 entry0");
        probe(8'd128, "R1 entry128");
        probe(8'd254, "R1 entry254");
        probe(8'd255, "R1 entry255 white");
        check_rdata("R6 idle");

        // R1: first colour write lands on red of entry 0
        wr(4'd4, 32'h11_ABCDEF);
        probe(8'd0, "R1 first write red of entry0");

        // R3: full triple, low bits ignored, order red/green/blue
        wr(4'd0, 32'h0A_000000);
        wr(4'd4, 32'h12_FFFFFF);
        wr(4'd4, 32'h34_000001);
        wr(4'd4, 32'h56_808080);
        probe(8'd10, "R3 triple entry10");
        // R4: pointer advanced to 11
        wr(4'd4, 32'h77_000000);
        probe(8'd11, "R4 advance to entry11");

        // R2: pointer write mid-triple restarts at red
        wr(4'd0, 32'h14_000000);
        wr(4'd4, 32'h21_000000);
        wr(4'd4, 32'h22_000000);
        wr(4'd0, 32'h14_000000);
        wr(4'd4, 32'h99_000000);
        probe(8'd20, "R2 restart at red");

        // R4: wrap 255 -> 0
        wr(4'd0, 32'hFF_000000);
        wr(4'd4, 32'h01_000000);
        wr(4'd4, 32'h02_000000);
        wr(4'd4, 32'h03_000000);
        probe(8'd255, "R4 entry255 loaded");
        wr(4'd4, 32'hC0_000000);
        probe(8'd0, "R4 wrap to entry0");

        // R5: ignored accesses (sequencer now at green of entry 0)
        wr(4'd8, 32'h5A_000000);
        wr(4'd2, 32'h5B_000000);
        wr(4'd12, 32'h5C_000000);
        bus_op(1'b0, 4'd4, 32'h5D_000000, 8'd0, 1'b0, "");
        bus_op(1'b0, 4'd0, 32'h30_000000, 8'd0, 1'b0, "");
        @(negedge clk);
        bus_addr = 4'd4; bus_wdata = 32'h5E_000000; bus_write = 1'b1; bus_valid = 1'b0;
        @(negedge clk);
        bus_write = 1'b0;
        probe(8'd0, "R5 entry0 untouched");
        probe(8'd48, "R5 entry48 untouched");
        wr(4'd4, 32'hE1_000000);
        probe(8'd0, "R5 sequencer kept green step");

        // R6: read cycle returns zero
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'd4;
        #1 check_rdata("R6 read offset4");
        bus_addr = 4'd0;
        #1 check_rdata("R6 read offset0");
        bus_valid = 1'b0;

        // R7: write and lookup of the same entry in the same cycle
        wr(4'd0, 32'h40_000000);
        bus_op(1'b1, 4'd4, 32'hA1_000000, 8'h40, 1'b1, "R7 same-cycle red");
        bus_op(1'b1, 4'd4, 32'hB2_000000, 8'h40, 1'b1, "R7 same-cycle green");
        bus_op(1'b1, 4'd4, 32'hC3_000000, 8'h40, 1'b1, "R7 same-cycle blue");
        // R7: lookup of another entry during a write
        bus_op(1'b1, 4'd4, 32'hD4_000000, 8'h40, 1'b1, "R7 other entry unchanged");
        probe(8'h41, "R7 entry41 red");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule